// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the small register window of a device through which several virtual machines share a memory area and signal one another. Software on the host side of the window sees four 32-bit registers in a 256-byte space.

- **Interrupt mask.**
- **Interrupt status.**
- **Own-position register.** It reports this machine's peer number once the shared memory is mapped.
- **Doorbell.** A write to it asks for a notification to a chosen peer on a chosen vector.

A single level interrupt is asserted while any status bit is set under its mask. Reading the status register hands back its value and empties it in the same access.

A doorbell word carries the destination peer in its upper half and the vector in its low byte. The block checks both fields against limits supplied on its inputs: the live peer count, and a per-peer vector count. Only a ring that passes both checks leaves the block, as a one-cycle notify pulse that carries the peer and the vector. A ring that fails either check is dropped without any trace.

Event bits arriving from outside are merged into the status register every cycle. Bits that arrive in the same cycle as a status read are kept.

Top module: `shm_doorbell_regs`

## Requirements
- R1: `irq` is high exactly when (status AND mask) is nonzero. It follows any change of mask or status on the clock edge that makes that change.
- R2: A write to byte offset 0 loads the mask. A read of offset 0 returns the mask.
- R3: `req_ready` is always high. Every accepted read gives one `rsp_valid` pulse on the next cycle, carrying the data. A write gives no response pulse.
- R4: A read of offset 4 returns the current status and clears the status to zero. Any `evt_bits` present in that same cycle are kept in the status after the read.
- R5: A write to offset 4 loads the written word into the status as-is. It does not clear bits by writing ones. `evt_bits` are ORed into the status on every cycle.
- R6: After reset, mask and status are zero, `irq` is low, and neither `rsp_valid` nor `ring_valid` is asserted.
- R7: On a write to offset 12, the destination is wdata[31:16] and the vector is wdata[7:0]. A ring is accepted only when the destination is below `peer_count`, the destination is below MAX_PEERS, and the vector is below that peer's vector count. The vector count of peer i is `peer_vec_cnt[8*i+7:8*i]`. An accepted ring drives `ring_valid` for exactly one cycle, on the cycle after the write, with `ring_peer` and `ring_vec` set. Any other ring drives nothing.
- R8: A read of offset 8 returns `own_id` zero-extended when `mem_mapped` is high, and 0xFFFFFFFF when it is low.
- R9: A read of any address other than 0, 4 and 8 returns zero. A write to offset 8 or to any undefined offset changes no state.
- R10: A write decodes `req_addr` with its two low bits cleared, so a write to 0x03 reaches the mask. A read decodes the exact byte address, so a read of 0x01 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always high; every request is accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| evt_bits | input | 32 | Incoming event bits, ORed into status |
| peer_count | input | 17 | Number of peers currently known |
| peer_vec_cnt | input | 8*MAX_PEERS | Vector count for each peer, 8 bits each |
| own_id | input | 16 | This machine's peer number |
| mem_mapped | input | 1 | Shared memory is mapped |
| irq | output | 1 | Level interrupt |
| ring_valid | output | 1 | Notify pulse |
| ring_peer | output | 16 | Notified peer |
| ring_vec | output | 8 | Notified vector |

## Verification
The bench builds the block with MAX_PEERS = 4 and sets `peer_count` to 3. The per-peer vector counts are 2, 0, 3 and 4. This puts every branch of the doorbell range check within reach of a full 6×6 sweep of destinations and vectors:

- a destination at or above `peer_count`;
- a destination above the table size;
- a peer that has no vectors;
- a vector just inside and just outside the limit.

The interrupt is swept over all 256 pairs of 4-bit status and mask values. Separate cases cover clear-on-read with a colliding event, loading status by write, unaligned addresses, and the position register in both mapping states.

// File: rtl/shm_db_pkg.sv
package shm_db_pkg;
    localparam int DW       = 32;
    localparam int AW       = 8;
    localparam int PEER_W   = 16;
    localparam int VEC_W    = 8;
    localparam int PCNT_W   = PEER_W + 1;

    localparam logic [AW-1:0] OFS_MASK = 8'h00;
    localparam logic [AW-1:0] OFS_STAT = 8'h04;
    localparam logic [AW-1:0] OFS_POS  = 8'h08;
    localparam logic [AW-1:0] OFS_RING = 8'h0C;
    localparam logic [AW-1:0] WR_ALIGN = 8'hFC;

    typedef enum logic [2:0] {
        SEL_MASK,
        SEL_STAT,
        SEL_POS,
        SEL_RING,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0]     mask;
        logic [DW-1:0]     stat;
        logic              rsp_v;
        logic [DW-1:0]     rdata;
        logic              ring_v;
        logic [PEER_W-1:0] ring_peer;
        logic [VEC_W-1:0]  ring_vec;
    } db_state_t;
endpackage

// File: rtl/shm_db_decode.sv
module shm_db_decode
    import shm_db_pkg::*;
#(
    parameter bit ALIGN = 1'b1
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    logic [AW-1:0] eff;

    generate
        if (ALIGN) begin : g_align
            assign eff = addr & WR_ALIGN;
        end else begin : g_exact
            assign eff = addr;
        end
    endgenerate

    always_comb begin
        case (eff)
            OFS_MASK: sel = SEL_MASK;
            OFS_STAT: sel = SEL_STAT;
            OFS_POS:  sel = SEL_POS;
            OFS_RING: sel = SEL_RING;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/shm_db_ring_check.sv
module shm_db_ring_check
    import shm_db_pkg::*;
#(
    parameter int MAX_PEERS = 4
) (
    input  logic [PEER_W-1:0]          dest,
    input  logic [VEC_W-1:0]           vec,
    input  logic [PCNT_W-1:0]          peer_count,
    input  logic [MAX_PEERS*VEC_W-1:0] peer_vec_cnt,
    output logic                       ok
);
    localparam int TBL_W = $clog2(MAX_PEERS + 1) + 1;

    logic [VEC_W-1:0] lim;
    logic             in_tbl;

    always_comb begin
        lim = '0;
        for (int i = 0; i < MAX_PEERS; i++) begin
            if (dest == PEER_W'(i)) lim = peer_vec_cnt[i*VEC_W +: VEC_W];
        end
        in_tbl = ({1'b0, dest} < PCNT_W'(MAX_PEERS));
        ok = in_tbl && ({1'b0, dest} < peer_count) && (vec < lim);
    end

    logic [TBL_W-1:0] unused_tbl;
    assign unused_tbl = TBL_W'(0);
endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
    import shm_db_pkg::*;
#(
    parameter int MAX_PEERS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [AW-1:0]              req_addr,
    input  logic [DW-1:0]              req_wdata,
    output logic                       rsp_valid,
    output logic [DW-1:0]              rsp_rdata,
    input  logic [DW-1:0]              evt_bits,
    input  logic [PCNT_W-1:0]          peer_count,
    input  logic [MAX_PEERS*VEC_W-1:0] peer_vec_cnt,
    input  logic [PEER_W-1:0]          own_id,
    input  logic                       mem_mapped,
    output logic                       irq,
    output logic                       ring_valid,
    output logic [PEER_W-1:0]          ring_peer,
    output logic [VEC_W-1:0]           ring_vec
);
    db_state_t st_d, st_q;
    reg_sel_e  wr_sel, rd_sel;
    logic      ring_ok;
    logic      do_wr, do_rd;
    logic [DW-1:0] stat_base;

    shm_db_decode #(.ALIGN(1'b1)) u_wr_dec (.addr(req_addr), .sel(wr_sel));
    shm_db_decode #(.ALIGN(1'b0)) u_rd_dec (.addr(req_addr), .sel(rd_sel));

    shm_db_ring_check #(.MAX_PEERS(MAX_PEERS)) u_ring_chk (
        .dest        (req_wdata[DW-1:DW-PEER_W]),
        .vec         (req_wdata[VEC_W-1:0]),
        .peer_count  (peer_count),
        .peer_vec_cnt(peer_vec_cnt),
        .ok          (ring_ok)
    );

    assign req_ready = 1'b1;
    assign do_wr = req_valid && req_write;
    assign do_rd = req_valid && !req_write;

    always_comb begin
        st_d        = st_q;
        st_d.rsp_v  = 1'b0;
        st_d.rdata  = '0;
        st_d.ring_v = 1'b0;
        stat_base   = st_q.stat;

        if (do_wr) begin
            case (wr_sel)
                SEL_MASK: st_d.mask = req_wdata;
                SEL_STAT: stat_base = req_wdata;
                SEL_RING: begin
                    if (ring_ok) begin
                        st_d.ring_v    = 1'b1;
                        st_d.ring_peer = req_wdata[DW-1:DW-PEER_W];
                        st_d.ring_vec  = req_wdata[VEC_W-1:0];
                    end
                end
                default: ;
            endcase
        end

        if (do_rd) begin
            st_d.rsp_v = 1'b1;
            case (rd_sel)
                SEL_MASK: st_d.rdata = st_q.mask;
                SEL_STAT: begin
                    st_d.rdata = st_q.stat;
                    stat_base  = '0;
                end
                SEL_POS:  st_d.rdata = mem_mapped ? {{(DW-PEER_W){1'b0}}, own_id} : '1;
                default:  st_d.rdata = '0;
            endcase
        end

        st_d.stat = stat_base | evt_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq        = |(st_q.stat & st_q.mask);
    assign rsp_valid  = st_q.rsp_v;
    assign rsp_rdata  = st_q.rdata;
    assign ring_valid = st_q.ring_v;
    assign ring_peer  = st_q.ring_peer;
    assign ring_vec   = st_q.ring_vec;
endmodule

// File: rtl/shm_db_checker.sv
module shm_db_checker
    import shm_db_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic [DW-1:0]     req_wdata,
    input logic              rsp_valid,
    input logic [DW-1:0]     rsp_rdata,
    input logic [DW-1:0]     evt_bits,
    input logic [PCNT_W-1:0] peer_count,
    input logic              mem_mapped,
    input logic              irq,
    input logic              ring_valid,
    input logic [PEER_W-1:0] ring_peer
);
    // R3: a read is answered on the next cycle
    a_r3_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R3: no response without a read
    a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R4: a status read with no colliding event leaves the interrupt low
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFS_STAT && evt_bits == '0) |=> !irq);

    // R1: the interrupt cannot rise without an event or a register write
    a_r1_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && evt_bits == '0 && !(req_valid && req_write)) |=> !irq);

    // R7: a destination outside the peer count never rings
    a_r7_bad_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr & WR_ALIGN) == OFS_RING
         && {1'b0, req_wdata[DW-1:DW-PEER_W]} >= peer_count) |=> !ring_valid);

    // R7: a notify pulse always names a peer within the count
    a_r7_ring_peer_range: assert property (@(posedge clk) disable iff (!rst_n)
        ring_valid |-> ({1'b0, ring_peer} < $past(peer_count)));

    // R8: unmapped position reads as all ones
    a_r8_pos_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFS_POS && !mem_mapped) |=> (rsp_rdata == '1));
endmodule

bind shm_doorbell_regs shm_db_checker u_db_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .evt_bits  (evt_bits),
    .peer_count(peer_count),
    .mem_mapped(mem_mapped),
    .irq       (irq),
    .ring_valid(ring_valid),
    .ring_peer (ring_peer)
);

// File: tb/shm_doorbell_regs_tb.sv
module shm_doorbell_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int PCOUNT     = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic        req_ready;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] evt_bits;
    logic [16:0] peer_count;
    logic [NP*8-1:0] peer_vec_cnt;
    logic [15:0] own_id;
    logic        mem_mapped;
    logic        irq, ring_valid;
    logic [15:0] ring_peer;
    logic [7:0]  ring_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shm_doorbell_regs #(.MAX_PEERS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_bits(evt_bits),
        .peer_count(peer_count), .peer_vec_cnt(peer_vec_cnt), .own_id(own_id),
        .mem_mapped(mem_mapped), .irq(irq), .ring_valid(ring_valid),
        .ring_peer(ring_peer), .ring_vec(ring_vec)
    );

    function automatic int vcnt(int p);
        case (p)
            0: return 2;
            1: return 0;
            2: return 3;
            3: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rsp_rdata;
        check("R3 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit exp_ok;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        evt_bits = '0; peer_count = 17'(PCOUNT); own_id = 16'h0002; mem_mapped = 1'b0;
        for (int i = 0; i < NP; i++) peer_vec_cnt[i*8 +: 8] = 8'(vcnt(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        check("R6 irq", {31'b0, irq}, 32'd0);
        check("R6 ring_valid", {31'b0, ring_valid}, 32'd0);
        check("R6 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R3 req_ready", {31'b0, req_ready}, 32'd1);
        rd(8'h00, d); check("R6 mask", d, 32'h0);
        rd(8'h04, d); check("R6 stat", d, 32'h0);
        @(negedge clk);
        check("R3 no rsp after idle", {31'b0, rsp_valid}, 32'd0);

        // R2 mask write / read
        wr(8'h00, 32'hA5A5_1234);
        check("R3 no rsp for write", {31'b0, rsp_valid}, 32'd0);
        rd(8'h00, d); check("R2 mask readback", d, 32'hA5A5_1234);

        // R1 sweep of status x mask
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                wr(8'h04, 32'(s));
                wr(8'h00, 32'(m));
                check("R1 irq level", {31'b0, irq}, {31'b0, ((s & m) != 0)});
            end
        end

        // R4 read clears; R5 write loads
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0000_000F);
        wr(8'h04, 32'h0000_0003);
        rd(8'h04, d); check("R5 write loads not w1c", d, 32'h3);
        check("R4 irq low after clearing read", {31'b0, irq}, 32'd0);
        rd(8'h04, d); check("R4 cleared", d, 32'h0);

        // R4 event colliding with read survives
        wr(8'h04, 32'h0000_0001);
        evt_bits = 32'h0000_0010;
        rd(8'h04, d);
        evt_bits = '0;
        check("R4 old value returned", d, 32'h1);
        rd(8'h04, d); check("R4 colliding event kept", d, 32'h10);

        // R5 events OR into status
        wr(8'h04, 32'h0000_0100);
        evt_bits = 32'h0000_0002;
        @(negedge clk);
        evt_bits = '0;
        rd(8'h04, d); check("R5 event OR", d, 32'h102);

        // R8 position
        rd(8'h08, d); check("R8 unmapped", d, 32'hFFFF_FFFF);
        mem_mapped = 1'b1;
        rd(8'h08, d); check("R8 mapped", d, 32'h0000_0002);

        // R9 ignored writes and unknown reads
        wr(8'h00, 32'h0000_00F0);
        wr(8'h04, 32'h0000_0000);
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h10, 32'hDEAD_BEEF);
        wr(8'hFC, 32'hDEAD_BEEF);
        rd(8'h00, d); check("R9 mask untouched", d, 32'h0000_00F0);
        rd(8'h04, d); check("R9 status untouched", d, 32'h0);
        rd(8'h08, d); check("R9 position untouched", d, 32'h0000_0002);
        rd(8'h10, d); check("R9 unknown read", d, 32'h0);
        rd(8'h0C, d); check("R9 doorbell read", d, 32'h0);

        // R10 alignment
        wr(8'h03, 32'h0000_5A5A);
        rd(8'h00, d); check("R10 unaligned write hits mask", d, 32'h0000_5A5A);
        rd(8'h01, d); check("R10 unaligned read is zero", d, 32'h0);

        // R7 doorbell sweep
        for (int p = 0; p < 6; p++) begin
            for (int v = 0; v < 6; v++) begin
                exp_ok = (p < PCOUNT) && (p < NP) && (v < vcnt(p));
                wr(8'h0C, {16'(p), 8'hEE, 8'(v)});
                check("R7 ring_valid", {31'b0, ring_valid}, {31'b0, exp_ok});
                if (exp_ok) begin
                    check("R7 ring_peer", {16'b0, ring_peer}, 32'(p));
                    check("R7 ring_vec", {24'b0, ring_vec}, 32'(v));
                end
                @(negedge clk);
                check("R7 single pulse", {31'b0, ring_valid}, 32'd0);
            end
        end
        wr(8'h0F, {16'd3, 8'h00, 8'd3});
        check("R10 R7 unaligned ring", {31'b0, ring_valid}, 32'd0);

        peer_count = 17'd4;
        wr(8'h0F, {16'd3, 8'h00, 8'd3});
        check("R7 ring after count grows", {31'b0, ring_valid}, 32'd1);
        check("R7 ring_peer 3", {16'b0, ring_peer}, 32'd3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule